// File: doc/BRIEF.md
# Debug Command Sequencer for an 8051 Debug Port

This block takes one high-level debug request at a time from a host controller. It turns that request into the series of byte transfers that an on-chip 8051 debug unit expects, and it passes those bytes to a bit-level transceiver below it. Simple requests map to a single command byte and a reply. Examples are halting the core, resuming it, stepping it, reading the status byte, reading the configuration or the chip identifier, and erasing the chip. Data-memory and code-memory accesses have no native command. The block builds each of them from short 8051 instructions that it injects one after another. Each injected instruction starts with a framing command byte whose two low bits carry the instruction length.

The host puts an opcode, a 17-bit address and a data byte on the inputs and pulses `start_i`. When the last link byte of the sequence has completed, the block pulses `done_o` for one cycle. In that cycle `result_o` holds the returned value and `err_o` tells whether the request failed. The transceiver side uses a level request with a per-byte acknowledge. The block holds each byte and its direction steady until the transceiver acknowledges it.

Top module: `dbg_seq`

## Requirements
- R1: Opcodes are encoded as follows: 0 halt, 1 resume, 2 step, 3 read status, 4 read config, 5 write config, 6 chip erase, 7 get PC, 8 set PC, 9 get ID, 10 data peek, 11 data poke, 12 code peek, 13 wait-for-halt. Opcodes 0, 1, 2, 3, 4 and 6 each write one command byte (0x44, 0x4C, 0x5C, 0x3F, 0x24 and 0x14 respectively) and then read one reply. The reply lands in `result_o[7:0]` and `result_o[15:8]` stays 0.
- R2: Write config writes 0x1D, then `data_i`, then reads one reply, which is returned in `result_o[7:0]`.
- R3: Get PC (command 0x28) and get ID (command 0x68) each write the command and then read two replies. The first reply becomes `result_o[15:8]` and the second becomes `result_o[7:0]`.
- R4: Set PC writes 0x02, then `addr_i[15:8]`, then `addr_i[7:0]`. It reads nothing and returns 0.
- R5: An injected instruction of length L (1 to 3) is one write of 0x54+L, then L instruction byte writes, then one read. Only the read of the final instruction of a peek is returned. All other replies are discarded.
- R6: Data peek injects 0x90 hi lo, then injects 0xE0 as a 3-byte instruction padded with 0x00 0x00. Its last reply is the result.
- R7: Data poke injects 0x90 hi lo, then 0x74 `data_i`, then the single byte 0xF0. It returns 0.
- R8: Code peek injects 0x75 0xC7 followed by a byte whose bits [5:4] are `addr_i[16:15]`, whose bits [3:0] are 1 and whose bits [7:6] are 0. It then injects 0x90 hi lo, then 0xE4 as a 2-byte instruction padded with 0x00, then 0x93 as a 3-byte instruction padded with zeros. The reply of the 0x93 instruction is the result.
- R9: Wait-for-halt repeats read status (0x3F, reply) until a reply has bit HALT_BIT set, and returns that reply. After MAX_POLLS replies with the bit clear, it finishes with `err_o` set.
- R10: Opcodes 14 and 15 finish one cycle after the start with `done_o` and `err_o` set and no byte request.
- R11: `done_o` is a one-cycle pulse in the cycle after the acknowledge of the final byte. `result_o` and `err_o` hold until the next accepted start, which clears them.
- R12: While `byte_req_o` is high and unacknowledged, `byte_tx_o` and `byte_wr_o` stay stable.
- R13: A start in idle with a supported opcode raises `byte_req_o` in the next cycle. A start while a sequence runs is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe |
| op_i | input | 4 | Request opcode |
| addr_i | input | 17 | Memory address or PC value |
| data_i | input | 8 | Data byte for poke or write config |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Request failed |
| result_o | output | 16 | Returned value |
| byte_req_o | output | 1 | Link byte request level |
| byte_wr_o | output | 1 | 1 for a byte write, 0 for a byte read |
| byte_tx_o | output | 8 | Byte to write |
| byte_ack_i | input | 1 | Current byte completed |
| byte_rx_i | input | 8 | Byte read, valid with the acknowledge |

## Verification
The assertions check the link-side invariants on every cycle. A pending byte and its direction must not change before they are acknowledged. No request may be pending when `done_o` pulses. An error may only rise together with a done pulse. Starts with unsupported and supported opcodes must behave as R10 and R13 say. Only the bench scenarios can show the byte orderings themselves: the framing of each injected instruction, the bank byte of a code peek, which replies are discarded or returned, and how the status polling ends in a halt or in a timeout.

// File: rtl/dbg_seq_pkg.sv
package dbg_seq_pkg;
  localparam int ADDR_W = 17;
  localparam int IDX_W  = 5;

  typedef enum logic [3:0] {
    OP_HALT = 4'd0, OP_RESUME = 4'd1, OP_STEP = 4'd2, OP_STATUS = 4'd3,
    OP_RD_CFG = 4'd4, OP_WR_CFG = 4'd5, OP_ERASE = 4'd6, OP_GET_PC = 4'd7,
    OP_SET_PC = 4'd8, OP_GET_ID = 4'd9, OP_PEEK_D = 4'd10, OP_POKE_D = 4'd11,
    OP_PEEK_C = 4'd12, OP_WAIT_HALT = 4'd13, OP_BAD14 = 4'd14, OP_BAD15 = 4'd15
  } op_e;

  typedef enum logic [1:0] {CAP_NONE, CAP_LO, CAP_HI} cap_e;

  typedef struct packed {
    logic       wr;
    logic [7:0] b;
    cap_e       cap;
  } step_t;

  function automatic step_t wr_b(logic [7:0] b);
    return '{wr: 1'b1, b: b, cap: CAP_NONE};
  endfunction

  function automatic step_t rd_s(cap_e c);
    return '{wr: 1'b0, b: 8'h00, cap: c};
  endfunction

  function automatic int seq_len(op_e op);
    case (op)
      OP_WR_CFG, OP_GET_PC, OP_SET_PC, OP_GET_ID: return 3;
      OP_PEEK_D: return 10;
      OP_POKE_D: return 12;
      OP_PEEK_C: return 19;
      default:   return 2;
    endcase
  endfunction
endpackage

// File: rtl/dbg_seq_step.sv
module dbg_seq_step
  import dbg_seq_pkg::*;
(
  input  op_e               op_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  output step_t             step_o,
  output logic              last_o
);
  logic [7:0] hi, lo, bank_b;
  assign hi     = addr_i[15:8];
  assign lo     = addr_i[7:0];
  assign bank_b = {2'b00, addr_i[16:15], 4'h1};
  assign last_o = (idx_i == IDX_W'(seq_len(op_i) - 1));

  always_comb begin
    step_o = rd_s(CAP_NONE);
    case (op_i)
      OP_HALT:    step_o = (idx_i == 0) ? wr_b(8'h44) : rd_s(CAP_LO);
      OP_RESUME:  step_o = (idx_i == 0) ? wr_b(8'h4C) : rd_s(CAP_LO);
      OP_STEP:    step_o = (idx_i == 0) ? wr_b(8'h5C) : rd_s(CAP_LO);
      OP_STATUS,
      OP_WAIT_HALT: step_o = (idx_i == 0) ? wr_b(8'h3F) : rd_s(CAP_LO);
      OP_RD_CFG:  step_o = (idx_i == 0) ? wr_b(8'h24) : rd_s(CAP_LO);
      OP_ERASE:   step_o = (idx_i == 0) ? wr_b(8'h14) : rd_s(CAP_LO);
      OP_WR_CFG:
        case (idx_i)
          0: step_o = wr_b(8'h1D);
          1: step_o = wr_b(data_i);
          default: step_o = rd_s(CAP_LO);
        endcase
      OP_GET_PC, OP_GET_ID:
        case (idx_i)
          0: step_o = wr_b(op_i == OP_GET_PC ? 8'h28 : 8'h68);
          1: step_o = rd_s(CAP_HI);
          default: step_o = rd_s(CAP_LO);
        endcase
      OP_SET_PC:
        case (idx_i)
          0: step_o = wr_b(8'h02);
          1: step_o = wr_b(hi);
          default: step_o = wr_b(lo);
        endcase
      OP_PEEK_D:
        case (idx_i)
          0, 5: step_o = wr_b(8'h57);
          1: step_o = wr_b(8'h90);
          2: step_o = wr_b(hi);
          3: step_o = wr_b(lo);
          6: step_o = wr_b(8'hE0);
          7, 8: step_o = wr_b(8'h00);
          9: step_o = rd_s(CAP_LO);
          default: step_o = rd_s(CAP_NONE);
        endcase
      OP_POKE_D:
        case (idx_i)
          0: step_o = wr_b(8'h57);
          1: step_o = wr_b(8'h90);
          2: step_o = wr_b(hi);
          3: step_o = wr_b(lo);
          5: step_o = wr_b(8'h56);
          6: step_o = wr_b(8'h74);
          7: step_o = wr_b(data_i);
          9: step_o = wr_b(8'h55);
          10: step_o = wr_b(8'hF0);
          default: step_o = rd_s(CAP_NONE);
        endcase
      OP_PEEK_C:
        case (idx_i)
          0, 5, 14: step_o = wr_b(8'h57);
          1: step_o = wr_b(8'h75);
          2: step_o = wr_b(8'hC7);
          3: step_o = wr_b(bank_b);
          6: step_o = wr_b(8'h90);
          7: step_o = wr_b(hi);
          8: step_o = wr_b(lo);
          10: step_o = wr_b(8'h56);
          11: step_o = wr_b(8'hE4);
          12, 16, 17: step_o = wr_b(8'h00);
          15: step_o = wr_b(8'h93);
          18: step_o = rd_s(CAP_LO);
          default: step_o = rd_s(CAP_NONE);
        endcase
      default: step_o = rd_s(CAP_NONE);
    endcase
  end
endmodule

// File: rtl/dbg_poll_timer.sv
module dbg_poll_timer #(
  parameter int MAX_POLLS = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic bump_i,
  output logic last_o
);
  localparam int CW = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (bump_i) cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == CW'(MAX_POLLS - 1));
endmodule

// File: rtl/dbg_seq.sv
module dbg_seq
  import dbg_seq_pkg::*;
#(
  parameter int HALT_BIT  = 5,
  parameter int MAX_POLLS = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic [3:0]  op_i,
  input  logic [16:0] addr_i,
  input  logic [7:0]  data_i,
  output logic        done_o,
  output logic        err_o,
  output logic [15:0] result_o,
  output logic        byte_req_o,
  output logic        byte_wr_o,
  output logic [7:0]  byte_tx_o,
  input  logic        byte_ack_i,
  input  logic [7:0]  byte_rx_i
);
  typedef enum logic {ST_IDLE, ST_BUSY} st_e;

  st_e               st_q;
  op_e               op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        data_q;
  logic [IDX_W-1:0]  idx_q;
  logic [15:0]       result_q;
  logic              err_q, done_q;
  step_t             step;
  logic              last, tmr_last, accept, op_ok, halted, poll_again;

  assign op_ok  = (op_i <= 4'd13);
  assign accept = (st_q == ST_IDLE) && start_i;
  assign halted = byte_rx_i[HALT_BIT];
  assign poll_again = (st_q == ST_BUSY) && byte_ack_i && last &&
                      (op_q == OP_WAIT_HALT) && !halted;

  dbg_seq_step u_step (
    .op_i   (op_q),
    .idx_i  (idx_q),
    .addr_i (addr_q),
    .data_i (data_q),
    .step_o (step),
    .last_o (last)
  );

  dbg_poll_timer #(.MAX_POLLS(MAX_POLLS)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (accept),
    .bump_i (poll_again && !tmr_last),
    .last_o (tmr_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      op_q     <= OP_HALT;
      addr_q   <= '0;
      data_q   <= '0;
      idx_q    <= '0;
      result_q <= '0;
      err_q    <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (st_q == ST_IDLE) begin
        if (start_i) begin
          result_q <= '0;
          idx_q    <= '0;
          if (op_ok) begin
            err_q  <= 1'b0;
            op_q   <= op_e'(op_i);
            addr_q <= addr_i;
            data_q <= data_i;
            st_q   <= ST_BUSY;
          end else begin
            err_q  <= 1'b1;
            done_q <= 1'b1;
          end
        end
      end else if (byte_ack_i) begin
        if (step.cap == CAP_LO) result_q[7:0]  <= byte_rx_i;
        if (step.cap == CAP_HI) result_q[15:8] <= byte_rx_i;
        if (!last) begin
          idx_q <= idx_q + 1'b1;
        end else if (poll_again && !tmr_last) begin
          idx_q <= '0;
        end else begin
          err_q  <= poll_again;
          done_q <= 1'b1;
          st_q   <= ST_IDLE;
        end
      end
    end
  end

  assign done_o     = done_q;
  assign err_o      = err_q;
  assign result_o   = result_q;
  assign byte_req_o = (st_q == ST_BUSY);
  assign byte_wr_o  = step.wr;
  assign byte_tx_o  = step.wr ? step.b : 8'h00;
endmodule

// File: rtl/dbg_seq_chk.sv
module dbg_seq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic [3:0]  op_i,
  input logic        done_o,
  input logic        err_o,
  input logic        byte_req_o,
  input logic        byte_wr_o,
  input logic [7:0]  byte_tx_o,
  input logic        byte_ack_i
);
  assert_req_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_req_o && !byte_ack_i |=> byte_req_o && $stable(byte_tx_o) && $stable(byte_wr_o));

  assert_done_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !byte_req_o);

  assert_err_with_done_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> done_o);

  assert_bad_op_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !byte_req_o && (op_i > 4'd13) |=> done_o && err_o && !byte_req_o);

  assert_accept_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !byte_req_o && (op_i <= 4'd13) |=> byte_req_o);
endmodule

bind dbg_seq dbg_seq_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .op_i       (op_i),
  .done_o     (done_o),
  .err_o      (err_o),
  .byte_req_o (byte_req_o),
  .byte_wr_o  (byte_wr_o),
  .byte_tx_o  (byte_tx_o),
  .byte_ack_i (byte_ack_i)
);

// File: tb/dbg_seq_test.sv
`timescale 1ns/1ps
module dbg_seq_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  op = '0;
  logic [16:0] addr = '0;
  logic [7:0]  data = '0;
  logic        done, err, req, wr, ack = 1'b0;
  logic [15:0] result;
  logic [7:0]  tx, rx = '0;

  int n_chk = 0, n_fail = 0, stab_bad = 0;
  logic       lw [64];
  logic [7:0] lb [64];
  int         ln = 0;
  logic       ew_q [64];
  logic [7:0] eb_q [64];
  int         en = 0;
  logic [7:0] rq [32];
  int         rq_i = 0;
  logic [15:0] got_res;
  logic        got_err;

  always #2 clk = ~clk;

  dbg_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .addr_i(addr),
    .data_i(data), .done_o(done), .err_o(err), .result_o(result),
    .byte_req_o(req), .byte_wr_o(wr), .byte_tx_o(tx), .byte_ack_i(ack),
    .byte_rx_i(rx)
  );

  // transceiver model: acknowledges each byte after three cycles
  initial begin : link_model
    int wcnt;
    logic seen, sw;
    logic [7:0] sb;
    wcnt = 0; seen = 1'b0; sw = 1'b0; sb = '0;
    forever begin
      @(negedge clk);
      if (ack) begin
        ack = 1'b0; rx = '0;
      end else if (req) begin
        if (!seen) begin seen = 1'b1; sw = wr; sb = tx; end
        else if (sw != wr || sb != tx) stab_bad++;
        wcnt++;
        if (wcnt == 3) begin
          if (ln < 64) begin lw[ln] = wr; lb[ln] = tx; end
          ln++;
          if (!wr) begin rx = rq[rq_i % 32]; rq_i++; end
          ack = 1'b1; wcnt = 0; seen = 1'b0;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  task automatic ew(input logic [7:0] b);
    ew_q[en] = 1'b1; eb_q[en] = b; en++;
  endtask
  task automatic er();
    ew_q[en] = 1'b0; eb_q[en] = 8'h00; en++;
  endtask

  task automatic chk_seq(input string tag);
    int bad;
    bad = -1;
    if (ln == en) begin
      for (int i = 0; i < en; i++)
        if (bad < 0 && (lw[i] != ew_q[i] || (ew_q[i] && lb[i] != eb_q[i]))) bad = i;
      chk(bad < 0, {tag, " byte"}, (bad < 0) ? 0 : {lw[bad], lb[bad]},
          (bad < 0) ? 0 : {ew_q[bad], eb_q[bad]});
    end else chk(1'b0, {tag, " length"}, ln, en);
  endtask

  // runs one request; optionally pulses a stray start while busy
  task automatic run_op(input int o, input logic [16:0] a, input logic [7:0] d,
                        input int stray_at);
    int cyc;
    ln = 0; rq_i = 0;
    @(negedge clk);
    op = 4'(o); addr = a; data = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 3000) begin
      @(negedge clk);
      cyc++;
      if (stray_at > 0 && cyc == stray_at) begin op = 4'd14; start = 1'b1; end
      if (stray_at > 0 && cyc == stray_at + 1) begin start = 1'b0; op = 4'(o); end
    end
    if (!done) chk(1'b0, "watchdog R11", 0, 1);
    got_res = result; got_err = err;
    @(negedge clk);
    chk(!done, "R11 done one cycle", done, 0);
    chk(result == got_res && err == got_err, "R11 result held", result, got_res);
  endtask

  task automatic t_reset();
    chk(!done && !err && !req && result == 0, "R11 reset state",
        {done, err, req, result}, 0);
  endtask

  task automatic t_single(input int o, input logic [7:0] code, input logic [7:0] rep);
    en = 0; ew(code); er();
    rq[0] = rep;
    run_op(o, 17'h0, 8'h00, 0);
    chk_seq("R1 single command");
    chk(got_res == {8'h00, rep} && !got_err, "R1 reply", got_res, {8'h00, rep});
  endtask

  task automatic t_wr_cfg();
    en = 0; ew(8'h1D); ew(8'h3C); er();
    rq[0] = 8'h9E;
    run_op(5, 17'h0, 8'h3C, 0);
    chk_seq("R2 write config");
    chk(got_res == 16'h009E, "R2 reply", got_res, 16'h009E);
  endtask

  task automatic t_two(input int o, input logic [7:0] code, input logic [15:0] v);
    en = 0; ew(code); er(); er();
    rq[0] = v[15:8]; rq[1] = v[7:0];
    run_op(o, 17'h0, 8'h00, 0);
    chk_seq("R3 two-byte read");
    chk(got_res == v, "R3 byte order", got_res, v);
  endtask

  task automatic t_set_pc();
    en = 0; ew(8'h02); ew(8'hBE); ew(8'hEF);
    run_op(8, 17'h0BEEF, 8'h00, 0);
    chk_seq("R4 set PC");
    chk(got_res == 0 && !got_err, "R4 result", got_res, 0);
  endtask

  task automatic t_peek_d(input int stray);
    en = 0;
    ew(8'h57); ew(8'h90); ew(8'h12); ew(8'h34); er();
    ew(8'h57); ew(8'hE0); ew(8'h00); ew(8'h00); er();
    rq[0] = 8'h11; rq[1] = 8'h77;
    run_op(10, 17'h01234, 8'h00, stray);
    chk_seq(stray > 0 ? "R13 stray start" : "R6 data peek");
    chk(got_res == 16'h0077 && !got_err, "R5 R6 discard and return", got_res, 16'h0077);
  endtask

  task automatic t_poke_d();
    en = 0;
    ew(8'h57); ew(8'h90); ew(8'hF0); ew(8'hA5); er();
    ew(8'h56); ew(8'h74); ew(8'h5A); er();
    ew(8'h55); ew(8'hF0); er();
    rq[0] = 8'h01; rq[1] = 8'h02; rq[2] = 8'h03;
    run_op(11, 17'h0F0A5, 8'h5A, 0);
    chk_seq("R7 data poke");
    chk(got_res == 0, "R5 R7 replies discarded", got_res, 0);
  endtask

  task automatic t_peek_c();
    en = 0;
    ew(8'h57); ew(8'h75); ew(8'hC7); ew(8'h31); er();
    ew(8'h57); ew(8'h90); ew(8'h9A); ew(8'hBC); er();
    ew(8'h56); ew(8'hE4); ew(8'h00); er();
    ew(8'h57); ew(8'h93); ew(8'h00); ew(8'h00); er();
    rq[0] = 8'h01; rq[1] = 8'h02; rq[2] = 8'h03; rq[3] = 8'h6E;
    run_op(12, 17'h19ABC, 8'h00, 0);
    chk_seq("R8 code peek");
    chk(got_res == 16'h006E, "R8 result", got_res, 16'h006E);
  endtask

  task automatic t_wait_ok();
    en = 0;
    for (int i = 0; i < 3; i++) begin ew(8'h3F); er(); end
    rq[0] = 8'h00; rq[1] = 8'hDF; rq[2] = 8'h20;
    run_op(13, 17'h0, 8'h00, 0);
    chk_seq("R9 poll until halted");
    chk(got_res == 16'h0020 && !got_err, "R9 halted status", got_res, 16'h0020);
  endtask

  task automatic t_wait_to();
    en = 0;
    for (int i = 0; i < 8; i++) begin ew(8'h3F); er(); rq[i] = 8'h00; end
    run_op(13, 17'h0, 8'h00, 0);
    chk_seq("R9 timeout polls");
    chk(got_err, "R9 timeout error", got_err, 1);
  endtask

  task automatic t_bad(input int o);
    run_op(o, 17'h0, 8'h00, 0);
    chk(ln == 0, "R10 no link activity", ln, 0);
    chk(got_err, "R10 error flag", got_err, 1);
  endtask

  initial begin : watchdog
    #(4 * 200000);
    chk(1'b0, "watchdog R11", 0, 1);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_single(0, 8'h44, 8'hA5);
    t_single(1, 8'h4C, 8'h12);
    t_single(2, 8'h5C, 8'h34);
    t_single(3, 8'h3F, 8'h56);
    t_single(4, 8'h24, 8'h78);
    t_single(6, 8'h14, 8'h9A);
    t_wr_cfg();
    t_two(7, 8'h28, 16'h1234);
    t_two(9, 8'h68, 16'hABCD);
    t_set_pc();
    t_peek_d(0);
    t_poke_d();
    t_peek_c();
    t_wait_ok();
    t_wait_to();
    t_bad(14);
    t_single(0, 8'h44, 8'h01);
    chk(!err, "R11 error cleared by next start", err, 0);
    t_bad(15);
    t_peek_d(6);
    chk(stab_bad == 0, "R12 byte held until ack", stab_bad, 0);
    summary();
  end
endmodule